// File: doc/BRIEF.md
# Hot-Plug Slot Power Sequencer

This block drives the three controls of one hot-plug expansion slot: the slot power enable, the bus and clock connect enable, and the slot reset (active low). Software writes a command with a single on/off bit, and the block then walks the controls through a fixed sequence of steps. Each step holds for a fixed number of clock cycles, set by a parameter, so the slot hardware has time to settle before the next control changes.

Two mode bits, loaded by a separate configuration write, shape a power-up. With the power-only bit set, the sequence stops once power is applied. The bus stays disconnected and reset stays asserted, so the slot's capability pins can be read at once. With the connect-last bit set (its reset value), reset is released before the bus is connected. With it clear, the bus is connected first. A strap input for a single slot without isolation switches forces connect-first ordering. A power-down runs the steps in reverse. A busy output is high while a sequence runs or waits to run. From reset it stays high until the first commanded sequence has completed.

Top module: `slot_pwr_seq`

## Requirements
- R1: After reset, `slot_pwr`=0, `slot_conn`=0, `slot_rst_n`=0, `busy`=1, `mode_pwr_only`=0 and `mode_conn_last`=1.
- R2: `busy` stays 1 from reset until the first commanded sequence completes. After that it is 1 exactly while a sequence runs or a command is pending. While `busy` is 0 and no command is written, the outputs do not change.
- R3: A power-up (`cmd_wr`=1, `cmd_on`=1) with connect-last ordering in effect raises `slot_pwr`, then `slot_rst_n`, then `slot_conn`, one per step.
- R4: With `mode_conn_last`=0, a full power-up raises `slot_pwr`, then `slot_conn`, then `slot_rst_n`, one per step.
- R5: `single_slot`=1 forces connect-first ordering, as in R4, even when `mode_conn_last`=1.
- R6: With `mode_pwr_only`=1, a power-up is one step: only `slot_pwr` rises, `slot_conn` and `slot_rst_n` stay 0, and `busy` falls at the end of that step.
- R7: After a power-only sequence, writing `mode_pwr_only`=0 and issuing a power-up completes the full enable.
- R8: A power-down (`cmd_on`=0) drops `slot_rst_n`, then `slot_conn`, then `slot_pwr`, one per step.
- R9: The first step's output changes on the clock edge that samples `cmd_wr`. Each step lasts exactly STEP_WAIT cycles. At most one slot control changes per clock edge.
- R10: A command written while `busy`=1 is latched and started one cycle after the current sequence ends. The latest such command wins.
- R11: The mode bits are loaded by `cfg_wr` and read back on `mode_pwr_only` and `mode_conn_last` from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_on | input | 1 | Command value: 1 power up, 0 power down |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_pwr_only | input | 1 | Power-only mode bit written by `cfg_wr` |
| cfg_conn_last | input | 1 | Connect-last ordering bit written by `cfg_wr` |
| single_slot | input | 1 | Strap: single slot without isolation switches |
| mode_pwr_only | output | 1 | Current power-only mode bit |
| mode_conn_last | output | 1 | Current connect-last mode bit |
| busy | output | 1 | Sequence running, pending, or not yet run since reset |
| slot_pwr | output | 1 | Slot power enable |
| slot_conn | output | 1 | Bus and clock connect enable |
| slot_rst_n | output | 1 | Slot reset, active low |

## Verification
A wrong state code or a wrong ordering latch shows up at the ports one edge after a step boundary, as the wrong control changing. The bench checks the first and the last cycle of every step, so an early or late change is caught within STEP_WAIT cycles. A lost pending command leaves the second sequence missing, which the first expected item of that sequence exposes. A stuck start-up flag shows as `busy` staying high after the first sequence.

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq #(
  parameter int STEP_WAIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic cmd_on,
  input  logic cfg_wr,
  input  logic cfg_pwr_only,
  input  logic cfg_conn_last,
  input  logic single_slot,
  output logic mode_pwr_only,
  output logic mode_conn_last,
  output logic busy,
  output logic slot_pwr,
  output logic slot_conn,
  output logic slot_rst_n
);
  localparam int CNT_W = (STEP_WAIT > 1) ? $clog2(STEP_WAIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_WAIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_U3, S_D1, S_D2, S_D3} st_t;

  st_t             st;
  logic [CNT_W-1:0] cnt;
  logic            seen, pend, pend_on, lat_po, lat_late;

  wire go       = cmd_wr | pend;
  wire go_on    = cmd_wr ? cmd_on : pend_on;
  wire step_end = (cnt == CNT_LAST);

  assign busy = ~seen | pend | (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_pwr_only  <= 1'b0;
      mode_conn_last <= 1'b1;
    end else if (cfg_wr) begin
      mode_pwr_only  <= cfg_pwr_only;
      mode_conn_last <= cfg_conn_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      seen       <= 1'b0;
      pend       <= 1'b0;
      pend_on    <= 1'b0;
      lat_po     <= 1'b0;
      lat_late   <= 1'b0;
      slot_pwr   <= 1'b0;
      slot_conn  <= 1'b0;
      slot_rst_n <= 1'b0;
    end else if (st == S_IDLE) begin
      if (go) begin
        pend <= 1'b0;
        cnt  <= '0;
        if (go_on) begin
          st       <= S_U1;
          slot_pwr <= 1'b1;
          lat_po   <= mode_pwr_only;
          lat_late <= mode_conn_last & ~single_slot;
        end else begin
          st         <= S_D1;
          slot_rst_n <= 1'b0;
        end
      end
    end else begin
      if (cmd_wr) begin
        pend    <= 1'b1;
        pend_on <= cmd_on;
      end
      if (!step_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        unique case (st)
          S_U1: begin
            if (lat_po) begin
              st   <= S_IDLE;
              seen <= 1'b1;
            end else begin
              st <= S_U2;
              if (lat_late) slot_rst_n <= 1'b1;
              else          slot_conn  <= 1'b1;
            end
          end
          S_U2: begin
            st <= S_U3;
            if (lat_late) slot_conn  <= 1'b1;
            else          slot_rst_n <= 1'b1;
          end
          S_U3: begin
            st   <= S_IDLE;
            seen <= 1'b1;
          end
          S_D1: begin
            st        <= S_D2;
            slot_conn <= 1'b0;
          end
          S_D2: begin
            st       <= S_D3;
            slot_pwr <= 1'b0;
          end
          S_D3: begin
            st   <= S_IDLE;
            seen <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_CONN_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    slot_conn |-> slot_pwr); // R3
  AST_RST_REL_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rst_n |-> slot_pwr); // R4
  AST_ONE_CTRL_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({slot_pwr, slot_conn, slot_rst_n} ^
               $past({slot_pwr, slot_conn, slot_rst_n})) <= 1); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_wr) |=> $stable({slot_pwr, slot_conn, slot_rst_n})); // R2
  AST_WR_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> busy); // R10
endmodule

// File: tb/slot_pwr_seq_tb.sv
`timescale 1ns/1ps
module slot_pwr_seq_tb;
  localparam int W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0, cmd_on = 1'b0, cfg_wr = 1'b0;
  logic cfg_pwr_only = 1'b0, cfg_conn_last = 1'b1, single_slot = 1'b0;
  logic mode_pwr_only, mode_conn_last, busy, slot_pwr, slot_conn, slot_rst_n;

  always #2.5 clk = ~clk;

  slot_pwr_seq #(.STEP_WAIT(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_on(cmd_on),
    .cfg_wr(cfg_wr), .cfg_pwr_only(cfg_pwr_only), .cfg_conn_last(cfg_conn_last),
    .single_slot(single_slot), .mode_pwr_only(mode_pwr_only),
    .mode_conn_last(mode_conn_last), .busy(busy), .slot_pwr(slot_pwr),
    .slot_conn(slot_conn), .slot_rst_n(slot_rst_n));

  typedef struct { int cyc; logic [3:0] v; string req; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit finished = 0;
  logic m_pwr = 0, m_conn = 0, m_rst = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {busy,pwr,conn,rst_n} actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      if (q[0].cyc < cyc) chk(4'bxxxx, q[0].v, {q[0].req, " (missed sample)"});
      else chk({busy, slot_pwr, slot_conn, slot_rst_n}, q[0].v, q[0].req);
      void'(q.pop_front());
    end
  end

  task automatic push_step(input int c, inout int k, input string req);
    k++;
    q.push_back('{c + 1 + (k-1)*W, {1'b1, m_pwr, m_conn, m_rst}, req});
    q.push_back('{c + k*W,         {1'b1, m_pwr, m_conn, m_rst}, req});
  endtask

  task automatic push_seq(input int c, input bit on, input bit po, input bit late,
                          input bit busy_after, input string req, output int n);
    int k = 0;
    if (on) begin
      m_pwr = 1; push_step(c, k, req);
      if (!po) begin
        if (late) m_rst = 1; else m_conn = 1;
        push_step(c, k, req);
        if (late) m_conn = 1; else m_rst = 1;
        push_step(c, k, req);
      end
    end else begin
      m_rst = 0; push_step(c, k, req);
      m_conn = 0; push_step(c, k, req);
      m_pwr = 0; push_step(c, k, req);
    end
    q.push_back('{c + 1 + k*W, {busy_after, m_pwr, m_conn, m_rst}, req});
    n = k;
  endtask

  task automatic do_cmd(input bit on, input bit po, input bit late, input string req);
    int n;
    @(negedge clk);
    push_seq(cyc, on, po, late, 1'b0, req, n);
    cmd_on = on; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
    repeat (n*W + 2) @(negedge clk);
  endtask

  task automatic do_cfg(input bit po, input bit last);
    @(negedge clk);
    cfg_pwr_only = po; cfg_conn_last = last; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
    chk({2'b00, mode_pwr_only, mode_conn_last}, {2'b00, po, last}, "R11 mode readback");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk({busy, slot_pwr, slot_conn, slot_rst_n}, 4'b1000, "R1 reset outputs");
    chk({2'b00, mode_pwr_only, mode_conn_last}, 4'b0001, "R1 reset modes");
    chk({3'b000, busy}, 4'b0001, "R2 busy held before first command");

    do_cmd(1, 0, 1, "R3 connect-last power-up, R9 step timing");
    do_cmd(0, 0, 0, "R8 power-down order");
    do_cfg(0, 0);
    do_cmd(1, 0, 0, "R4 connect-first power-up");
    do_cmd(0, 0, 0, "R8 power-down after connect-first");
    do_cfg(1, 1);
    do_cmd(1, 1, 0, "R6 power-only");
    do_cfg(0, 1);
    do_cmd(1, 0, 1, "R7 full enable after power-only");
    do_cmd(0, 0, 0, "R8 power-down after R7");
    single_slot = 1;
    do_cmd(1, 0, 0, "R5 single slot forces connect-first");
    single_slot = 0;

    begin : pending_case
      int n1, n2, c;
      @(negedge clk);
      c = cyc;
      push_seq(c, 0, 0, 0, 1'b1, "R10 first of queued pair", n1);
      cmd_on = 0; cmd_wr = 1;
      @(negedge clk); cmd_wr = 0;
      repeat (2) @(negedge clk);
      cmd_on = 0; cmd_wr = 1;
      @(negedge clk); cmd_on = 1;
      @(negedge clk); cmd_wr = 0;
      push_seq(c + 1 + n1*W, 1, 0, 1, 1'b0, "R10 queued command runs after", n2);
      repeat ((n1 + n2)*W + 4) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    chk({3'b000, busy}, 4'b0000, "R2 idle after queue drained");
    if (q.size() != 0) begin
      fails++; checks++;
      $display("FAIL R9: %0d expected items left, expected 0", q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule